// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a logical address made of a segment register and a 16-bit offset into a 20-bit physical address. Four segment registers are held inside it: code, data, stack and extra. Each request carries an access type, and the type chooses the segment register. Only data requests may name a different register through an override.

In real mode the chosen register value is scaled by sixteen and added to the offset. In protected mode the chosen register is a selector that picks an entry from a small descriptor table. The entry gives a base, an inclusive limit and four attribute bits. The offset is checked against the limit, and the entry's attributes are checked against the kind of access. A request that fails any check returns a fault with a cause code and no address.

Segment registers and descriptors are loaded through a single write port. A result appears one cycle after each request.

Top module: `seg_xlate`

## Requirements
- R1: With `prot_i`=0, `paddr_o` = ((segment << 4) + offset) mod 2^20. Real mode never faults, whatever the access type or `write_i`.
- R2: The access type selects the segment register. `acc_type_i` 0 is a code fetch and uses CS (index 0). Type 1 is data and uses DS (index 1). Type 2 is stack and uses SS (index 2). Type 3 is treated as data.
- R3: When `ovr_en_i`=1, a data request uses the register named by `ovr_seg_i` (0 CS, 1 DS, 2 SS, 3 ES). Code and stack requests ignore the override.
- R4: With `prot_i`=1, the register value is a descriptor index. A successful request returns `paddr_o` = (base + offset) mod 2^20.
- R5: The limit is inclusive. A code or data offset above the limit faults with cause 3. A stack access is a word, so it also faults when the offset equals the limit.
- R6: A descriptor whose present bit is clear faults with cause 2.
- R7: A code fetch from a descriptor without the executable bit faults with cause 6, and a code fetch ignores `write_i`. A data or stack write without the writable bit faults with cause 4. A data or stack read without the readable bit faults with cause 5.
- R8: A selector value of NDESC or above faults with cause 1.
- R9: When several faults apply, only the first in this order is reported: selector range (1), not present (2), limit (3), permission (4, 5 or 6).
- R10: Each request with `req_i` high gives exactly one cycle, one clock later, in which exactly one of `valid_o` and `fault_o` is high. On a fault, `paddr_o` is 0. With no request, both are low and `cause_o` is 0.
- R11: After reset, all outputs are 0, all segment registers are 0, and every descriptor reads as all zero, which makes it not present.
- R12: A write with `cfg_tbl_i`=1 loads descriptor `cfg_idx_i`. The data layout is base in bits 19:0, limit in 35:20, present in bit 36, readable in 37, writable in 38 and executable in 39. A write with `cfg_tbl_i`=0 loads bits 15:0 into segment register `cfg_idx_i` when the index is 0 to 3. Indices 4 and above are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the configuration port |
| cfg_tbl_i | input | 1 | Write target: 1 selects the descriptor table, 0 selects a segment register |
| cfg_idx_i | input | IDX_W | Index of the descriptor or segment register to write |
| cfg_wdata_i | input | 40 | Write data |
| req_i | input | 1 | Translation request |
| prot_i | input | 1 | Mode select: 1 protected, 0 real |
| acc_type_i | input | 2 | Access type |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Segment register named by the override |
| write_i | input | 1 | 1 for a write, 0 for a read |
| offset_i | input | 16 | Offset |
| valid_o | output | 1 | Translation succeeded |
| fault_o | output | 1 | Translation faulted |
| cause_o | output | 3 | Fault cause code |
| paddr_o | output | 20 | Physical address |

## Verification
The bench aims at the following corner cases.

- **Address wrap.** Both modes must wrap above 1 MB. A design that kept the carry would emit a 21st bit or a wrong low address.
- **Limit boundary.** An offset equal to the limit is tested for both code and stack. A design that used a strict or a loose compare would accept a straddling stack word, or reject the last legal byte.
- **Override scope.** The override is applied to code and stack requests, where it must have no effect. A design that honoured it there would return the wrong address.
- **Fault priority.** Several faults are stacked on one request. A design with the wrong priority would report the wrong cause.
- **Selector range.** A selector beyond the table is tested. A design that truncated the selector would alias it onto a real entry.
- **Back-to-back requests.** Requests on consecutive cycles must each produce one result. A design with stretched strobes would show a strobe in the idle cycle that follows.

// File: rtl/seg_pkg.sv
package seg_pkg;
  parameter int unsigned OFF_W   = 16;
  parameter int unsigned SEG_W   = 16;
  parameter int unsigned SHIFT   = 4;
  parameter int unsigned PA_W    = SEG_W + SHIFT;
  parameter int unsigned CAUSE_W = 3;
  parameter int unsigned NSEG    = 4;

  typedef enum logic [1:0] {ACC_CODE = 2'd0, ACC_DATA = 2'd1, ACC_STACK = 2'd2, ACC_RSVD = 2'd3} acc_e;
  typedef enum logic [1:0] {SR_CS = 2'd0, SR_DS = 2'd1, SR_SS = 2'd2, SR_ES = 2'd3} sreg_e;
  typedef enum logic [CAUSE_W-1:0] {
    FLT_NONE = 3'd0, FLT_SEL = 3'd1, FLT_NP = 3'd2, FLT_LIMIT = 3'd3,
    FLT_WRPROT = 3'd4, FLT_EXONLY = 3'd5, FLT_NOEXEC = 3'd6
  } cause_e;

  typedef struct packed {
    logic             ex;
    logic             wr;
    logic             rd;
    logic             pres;
    logic [OFF_W-1:0] limit;
    logic [PA_W-1:0]  base;
  } desc_t;

  parameter int unsigned DESC_W = $bits(desc_t);
endpackage

// File: rtl/seg_regs.sv
module seg_regs import seg_pkg::*; #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [SEG_W-1:0] wdata_i,
  output logic [SEG_W-1:0] seg_o [NSEG]
);
  logic [SEG_W-1:0] seg_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seg_q[g] <= '0;
      else if (we_i && 32'(idx_i) == g) seg_q[g] <= wdata_i;
    end
    assign seg_o[g] = seg_q[g];
  end

  // R12: an in-range write lands in the addressed register
  p_seg_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && 32'(idx_i) < NSEG) |=> seg_o[$past(idx_i[1:0])] == $past(wdata_i));
endmodule

// File: rtl/seg_desc_tbl.sv
module seg_desc_tbl import seg_pkg::*; #(
  parameter int unsigned NDESC = 8,
  parameter int unsigned IDX_W = $clog2(NDESC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  desc_t            wdata_i,
  input  logic [SEG_W-1:0] sel_i,
  output desc_t            desc_o,
  output logic             in_range_o
);
  desc_t tbl_q [NDESC];

  for (genvar g = 0; g < NDESC; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tbl_q[g] <= '0;
      else if (we_i && 32'(idx_i) == g) tbl_q[g] <= wdata_i;
    end
  end

  // full-width compare so large selectors never alias onto an entry
  assign in_range_o = 32'(sel_i) < NDESC;
  assign desc_o     = in_range_o ? tbl_q[sel_i[IDX_W-1:0]] : '0;

  // R12: a descriptor write is visible through the lookup port
  p_tbl_write_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl_q[$past(idx_i)] == $past(wdata_i));
endmodule

// File: rtl/seg_check.sv
module seg_check import seg_pkg::*; (
  input  logic             prot_i,
  input  acc_e             acc_i,
  input  logic             write_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [SEG_W-1:0] seg_i,
  input  desc_t            desc_i,
  input  logic             in_range_i,
  output logic [PA_W-1:0]  paddr_o,
  output cause_e           cause_o
);
  logic is_code, is_stack, over;

  assign is_code  = acc_i == ACC_CODE;
  assign is_stack = acc_i == ACC_STACK;
  // stack word needs offset+1 inside the limit as well
  assign over     = (off_i > desc_i.limit) || (is_stack && off_i == desc_i.limit);

  always_comb begin
    cause_o = FLT_NONE;
    if (!prot_i) begin
      paddr_o = {seg_i, {SHIFT{1'b0}}} + PA_W'(off_i);
    end else begin
      paddr_o = desc_i.base + PA_W'(off_i);
      if (!in_range_i)                  cause_o = FLT_SEL;
      else if (!desc_i.pres)            cause_o = FLT_NP;
      else if (over)                    cause_o = FLT_LIMIT;
      else if (is_code) begin
        if (!desc_i.ex)                 cause_o = FLT_NOEXEC;
      end else if (write_i) begin
        if (!desc_i.wr)                 cause_o = FLT_WRPROT;
      end else if (!desc_i.rd)          cause_o = FLT_EXONLY;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate import seg_pkg::*; #(
  parameter  int unsigned NDESC = 8,
  localparam int unsigned IDX_W = $clog2(NDESC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_tbl_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic [DESC_W-1:0]  cfg_wdata_i,
  input  logic               req_i,
  input  logic               prot_i,
  input  logic [1:0]         acc_type_i,
  input  logic               ovr_en_i,
  input  logic [1:0]         ovr_seg_i,
  input  logic               write_i,
  input  logic [OFF_W-1:0]   offset_i,
  output logic               valid_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [PA_W-1:0]    paddr_o
);
  logic [SEG_W-1:0] seg_vals [NSEG];
  logic [SEG_W-1:0] seg_sel;
  sreg_e            sr;
  acc_e             acc;
  desc_t            desc;
  logic             in_range;
  logic [PA_W-1:0]  paddr_d;
  cause_e           cause_d;

  seg_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i    (cfg_we_i && !cfg_tbl_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i[SEG_W-1:0]),
    .seg_o   (seg_vals)
  );

  assign acc = acc_e'(acc_type_i);

  always_comb begin
    unique case (acc)
      ACC_CODE:  sr = SR_CS;
      ACC_STACK: sr = SR_SS;
      default:   sr = ovr_en_i ? sreg_e'(ovr_seg_i) : SR_DS;
    endcase
  end
  assign seg_sel = seg_vals[sr];

  seg_desc_tbl #(.NDESC(NDESC), .IDX_W(IDX_W)) u_tbl (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i && cfg_tbl_i),
    .idx_i      (cfg_idx_i),
    .wdata_i    (desc_t'(cfg_wdata_i)),
    .sel_i      (seg_sel),
    .desc_o     (desc),
    .in_range_o (in_range)
  );

  seg_check u_chk (
    .prot_i, .acc_i (acc), .write_i, .off_i (offset_i), .seg_i (seg_sel),
    .desc_i (desc), .in_range_i (in_range), .paddr_o (paddr_d), .cause_o (cause_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      fault_o <= 1'b0;
      cause_o <= '0;
      paddr_o <= '0;
    end else begin
      valid_o <= req_i && cause_d == FLT_NONE;
      fault_o <= req_i && cause_d != FLT_NONE;
      cause_o <= req_i ? cause_d : FLT_NONE;
      paddr_o <= (req_i && cause_d == FLT_NONE) ? paddr_d : '0;
    end
  end

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && fault_o));
  p_resp_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (valid_o || fault_o));
  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !fault_o && cause_o == '0));
  p_fault_noaddr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> paddr_o == '0);
  p_real_nofault_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !prot_i) |=> valid_o);
  p_sel_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && prot_i && !in_range) |=> (fault_o && cause_o == 3'd1));
endmodule

// File: tb/sim_seg_xlate.sv
module sim_seg_xlate;
  localparam int CLK_P = 10;
  localparam int NV    = 32;

  typedef struct packed {
    logic [2:0]  ph;
    logic        prot;
    logic [1:0]  typ;
    logic        oen;
    logic [1:0]  oseg;
    logic        wr;
    logic [15:0] off;
    logic        ev;
    logic [2:0]  ec;
    logic [19:0] ea;
    logic [3:0]  rq;
  } vec_t;

  // phase 1 real: CS 1000 DS 2345 SS 3000 ES FFFF
  // phase 2 prot: CS0 DS1 SS2 ES3 ; phase 3: CS4 DS9 SS5 ES6 ; phase 4: CS1
  localparam vec_t VECS [NV] = '{
    '{3'd1,1'b0,2'd0,1'b0,2'd0,1'b0,16'h0010,1'b1,3'd0,20'h10010,4'd1},  // R1
    '{3'd1,1'b0,2'd1,1'b0,2'd0,1'b0,16'h0005,1'b1,3'd0,20'h23455,4'd2},  // R2
    '{3'd1,1'b0,2'd2,1'b0,2'd0,1'b0,16'hFFFE,1'b1,3'd0,20'h3FFFE,4'd2},  // R2
    '{3'd1,1'b0,2'd1,1'b1,2'd3,1'b0,16'h0020,1'b1,3'd0,20'h00010,4'd1},  // R1 wrap
    '{3'd1,1'b0,2'd0,1'b1,2'd3,1'b0,16'h0010,1'b1,3'd0,20'h10010,4'd3},  // R3
    '{3'd1,1'b0,2'd2,1'b1,2'd3,1'b0,16'h0004,1'b1,3'd0,20'h30004,4'd3},  // R3
    '{3'd1,1'b0,2'd1,1'b1,2'd0,1'b1,16'h0001,1'b1,3'd0,20'h10001,4'd3},  // R3
    '{3'd1,1'b0,2'd1,1'b1,2'd2,1'b0,16'hFFFF,1'b1,3'd0,20'h3FFFF,4'd3},  // R3
    '{3'd2,1'b1,2'd0,1'b0,2'd0,1'b0,16'h0100,1'b1,3'd0,20'h40100,4'd4},  // R4
    '{3'd2,1'b1,2'd0,1'b0,2'd0,1'b0,16'h0FFF,1'b1,3'd0,20'h40FFF,4'd5},  // R5
    '{3'd2,1'b1,2'd0,1'b0,2'd0,1'b0,16'h1000,1'b0,3'd3,20'h00000,4'd5},  // R5
    '{3'd2,1'b1,2'd1,1'b0,2'd0,1'b0,16'h00FF,1'b1,3'd0,20'h500FF,4'd5},  // R5
    '{3'd2,1'b1,2'd1,1'b0,2'd0,1'b0,16'h0100,1'b0,3'd3,20'h00000,4'd5},  // R5
    '{3'd2,1'b1,2'd1,1'b0,2'd0,1'b1,16'h0010,1'b1,3'd0,20'h50010,4'd4},  // R4
    '{3'd2,1'b1,2'd2,1'b0,2'd0,1'b0,16'h00FF,1'b1,3'd0,20'h600FF,4'd5},  // R5
    '{3'd2,1'b1,2'd2,1'b0,2'd0,1'b0,16'h0100,1'b0,3'd3,20'h00000,4'd5},  // R5 stack word
    '{3'd2,1'b1,2'd0,1'b0,2'd0,1'b1,16'h0000,1'b1,3'd0,20'h40000,4'd7},  // R7
    '{3'd2,1'b1,2'd1,1'b1,2'd0,1'b1,16'h0010,1'b0,3'd4,20'h00000,4'd7},  // R7
    '{3'd2,1'b1,2'd1,1'b1,2'd3,1'b0,16'h0020,1'b0,3'd5,20'h00000,4'd7},  // R7
    '{3'd2,1'b1,2'd0,1'b1,2'd1,1'b0,16'h0010,1'b1,3'd0,20'h40010,4'd3},  // R3
    '{3'd3,1'b1,2'd0,1'b0,2'd0,1'b0,16'h0000,1'b0,3'd2,20'h00000,4'd6},  // R6
    '{3'd3,1'b1,2'd1,1'b0,2'd0,1'b0,16'h0000,1'b0,3'd1,20'h00000,4'd8},  // R8
    '{3'd3,1'b1,2'd1,1'b1,2'd2,1'b0,16'h0020,1'b1,3'd0,20'hFFF20,4'd3},  // R3
    '{3'd3,1'b1,2'd2,1'b0,2'd0,1'b0,16'h0200,1'b1,3'd0,20'h00100,4'd4},  // R4 wrap
    '{3'd3,1'b1,2'd1,1'b0,2'd0,1'b1,16'hFFFF,1'b0,3'd1,20'h00000,4'd9},  // R9
    '{3'd3,1'b1,2'd0,1'b0,2'd0,1'b0,16'h0020,1'b0,3'd2,20'h00000,4'd9},  // R9
    '{3'd3,1'b1,2'd1,1'b1,2'd3,1'b0,16'h0020,1'b0,3'd3,20'h00000,4'd9},  // R9
    '{3'd3,1'b1,2'd1,1'b1,2'd3,1'b0,16'h0008,1'b0,3'd5,20'h00000,4'd7},  // R7
    '{3'd3,1'b1,2'd1,1'b1,2'd1,1'b0,16'h0000,1'b0,3'd1,20'h00000,4'd8},  // R8
    '{3'd4,1'b1,2'd0,1'b0,2'd0,1'b0,16'h0010,1'b0,3'd6,20'h00000,4'd7},  // R7
    '{3'd4,1'b0,2'd0,1'b0,2'd0,1'b0,16'h0010,1'b1,3'd0,20'h00020,4'd1},  // R1
    '{3'd4,1'b1,2'd3,1'b0,2'd0,1'b0,16'h0000,1'b0,3'd1,20'h00000,4'd2}   // R2
  };

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 0, cfg_tbl = 0;
  logic [2:0]  cfg_idx = 0;
  logic [39:0] cfg_wdata = 0;
  logic        req = 0, prot = 0, oen = 0, wr = 0;
  logic [1:0]  typ = 0, oseg = 0;
  logic [15:0] off = 0;
  logic        valid, fault;
  logic [2:0]  cause;
  logic [19:0] paddr;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_P/2) clk = ~clk;

  seg_xlate u0 (
    .clk_i(clk), .rst_ni, .cfg_we_i(cfg_we), .cfg_tbl_i(cfg_tbl), .cfg_idx_i(cfg_idx),
    .cfg_wdata_i(cfg_wdata), .req_i(req), .prot_i(prot), .acc_type_i(typ),
    .ovr_en_i(oen), .ovr_seg_i(oseg), .write_i(wr), .offset_i(off),
    .valid_o(valid), .fault_o(fault), .cause_o(cause), .paddr_o(paddr)
  );

  task automatic chk(input bit ok, input int rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic chk_out(input int rq, input logic ev, input logic [2:0] ec, input logic [19:0] ea);
    chk({valid, fault, cause, paddr} == {ev, !ev, ec, ea}, rq, "result",
        {8'h0, valid, fault, 3'b0, cause, paddr[19:0]}, {8'h0, ev, !ev, 3'b0, ec, ea});
  endtask

  task automatic cfg(input logic t, input logic [2:0] i, input logic [39:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_tbl = t; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic logic [39:0] mkd(input logic [19:0] b, input logic [15:0] l,
                                      input logic p, input logic r, input logic w, input logic x);
    return {x, w, r, p, l, b};
  endfunction

  task automatic drive(input logic pr, input logic [1:0] t, input logic oe,
                       input logic [1:0] os, input logic w, input logic [15:0] o);
    req = 1; prot = pr; typ = t; oen = oe; oseg = os; wr = w; off = o;
  endtask

  task automatic load_phase(input int p);
    case (p)
      1: begin
        cfg(0, 0, 40'h1000); cfg(0, 1, 40'h2345); cfg(0, 2, 40'h3000); cfg(0, 3, 40'hFFFF);
        cfg(1, 0, mkd(20'h40000, 16'h0FFF, 1, 1, 0, 1));
        cfg(1, 1, mkd(20'h50000, 16'h00FF, 1, 1, 1, 0));
        cfg(1, 2, mkd(20'h60000, 16'h0100, 1, 1, 1, 0));
        cfg(1, 3, mkd(20'hF0000, 16'hFFFF, 1, 0, 0, 1));
        cfg(1, 4, mkd(20'h12345, 16'h0010, 0, 1, 1, 0));
        cfg(1, 5, mkd(20'hFFF00, 16'hFFFF, 1, 1, 1, 0));
        cfg(1, 6, mkd(20'h00000, 16'h0010, 1, 0, 0, 1));
      end
      2: begin cfg(0, 0, 0); cfg(0, 1, 1); cfg(0, 2, 2); cfg(0, 3, 3); end
      3: begin cfg(0, 0, 4); cfg(0, 1, 9); cfg(0, 2, 5); cfg(0, 3, 6); end
      default: cfg(0, 0, 1);
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int cur_ph;
    cur_ph = 0;
    repeat (3) @(negedge clk);
    chk({valid, fault, cause, paddr} == '0, 11, "reset outputs (R11)", {valid, fault, cause, paddr}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk({valid, fault, cause, paddr} == '0, 11, "idle after reset (R11)", {valid, fault, cause, paddr}, 0);

    // R11: cleared descriptor 0 is not present; cleared segments give paddr = offset
    drive(1, 1, 0, 0, 0, 16'h0000); @(negedge clk); req = 0;
    chk_out(11, 0, 3'd2, 20'h0);
    drive(0, 0, 0, 0, 0, 16'h1234); @(negedge clk); req = 0;
    chk_out(11, 1, 3'd0, 20'h01234);

    for (int i = 0; i < NV; i++) begin
      if (int'(VECS[i].ph) != cur_ph) begin
        cur_ph = int'(VECS[i].ph);
        load_phase(cur_ph);
        @(negedge clk);
      end
      drive(VECS[i].prot, VECS[i].typ, VECS[i].oen, VECS[i].oseg, VECS[i].wr, VECS[i].off);
      @(negedge clk);
      req = 0;
      chk_out(int'(VECS[i].rq), VECS[i].ev, VECS[i].ec, VECS[i].ea);
    end

    // R10: back-to-back requests, then an idle cycle (state: CS=1, DS=9)
    drive(0, 0, 0, 0, 0, 16'h0000); @(negedge clk);
    chk_out(10, 1, 3'd0, 20'h00010);
    drive(1, 0, 0, 0, 0, 16'h0010); @(negedge clk);
    req = 0;
    chk_out(10, 0, 3'd6, 20'h0);
    @(negedge clk);
    chk({valid, fault, cause} == '0, 10, "idle strobes (R10)", {valid, fault, cause}, 0);

    // R12: segment write with index 5 has no effect on DS (9)
    cfg(0, 5, 40'h7777);
    drive(0, 1, 0, 0, 0, 16'h0000); @(negedge clk); req = 0;
    chk_out(12, 1, 3'd0, 20'h00090);
    // R12: rewrite descriptor 1 and read through ES override in protected mode (ES=6 -> set ES=1)
    cfg(0, 3, 1);
    cfg(1, 1, mkd(20'hABCD0, 16'h0004, 1, 1, 0, 0));
    drive(1, 1, 1, 3, 0, 16'h0004); @(negedge clk); req = 0;
    chk_out(12, 1, 3'd0, 20'hABCD4);
    drive(1, 1, 1, 3, 1, 16'h0004); @(negedge clk); req = 0;
    chk_out(12, 0, 3'd4, 20'h0);

    @(negedge clk);
    finish_run();
  end
endmodule